// File: doc/BRIEF.md
# Named Barrier Synchronization Unit

This block keeps the barrier state for one multiprocessor. It holds sixteen named barriers that the warps of a thread block share. A warp posts a request on one of several request ports. Each request names the warp, the barrier, an operation and the number of threads that the barrier must collect before it completes. There are two operations. A sync request holds the issuing warp until the barrier completes. An arrive request adds to the count and lets the warp run on.

Each accepted request adds the thread count of one warp to its barrier. The first request of a generation fixes the barrier's target. The request that brings the running total to the target or beyond completes the barrier. On completion the running total returns to zero, the generation counter advances, and every warp held on that barrier is released together. The barrier id can then be used again. A block-wide barrier is simply a sync on barrier 0 whose count equals every thread of the block. Requests on different ports that name different barriers are processed independently in the same cycle. The unit sets sticky flags when requests disagree on the target and when a barrier collects more threads than its target.

Top module: `nbar_unit`

## Requirements
- R1: Requests on different ports that name different barriers in the same cycle are handled independently. Each barrier completes on its own, and both completions appear on `bar_done` in the same cycle.
- R2: An accepted sync (`req_op` = 0) that does not complete its barrier drives `warp_stall` of the issuing warp high from the next cycle. That bit stays high until its barrier completes.
- R3: An accepted arrive (`req_op` = 1) adds to its barrier's count and never raises `warp_stall` of the issuing warp.
- R4: Each accepted request adds 32 threads to its barrier, including several requests to one barrier in the same cycle. A barrier completes on the edge where its total reaches or passes the target, and `bar_done[b]` pulses high for one cycle after that edge.
- R5: On completion, every warp held on that barrier is released in the same cycle. Its `warp_stall` bit drops and its `warp_release` bit pulses high for one cycle. A sync that completes its barrier directly also gets a one-cycle `warp_release` pulse and never stalls.
- R6: On completion, a barrier's count returns to zero and its `bar_gen` entry (GEN_W = 4 bits, so modulo 16) advances by one, which allows the barrier to be reused. `bar_gen` of every barrier is always visible.
- R7: A sync on barrier 0 by all 16 warps with count 512 holds warps until the last one arrives, then releases all 16 together.
- R8: `err_mismatch[b]` is set, and stays set until reset, when an accepted request carries a count different from the target fixed by the first request of the barrier's current generation. It is also set when requests reaching an empty barrier in the same cycle disagree. The lowest port sets the target.
- R9: `err_overflow[b]` is set, and stays set until reset, when the total at completion is strictly above the target.
- R10: A request from a warp whose `warp_stall` bit is high is ignored. It adds no threads and changes no state.
- R11: After reset all counts and generations are zero, and no warp is stalled or released. No barrier is done and no error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORT | Request present on each port |
| req_warp | input | NPORT x WID_W | Issuing warp id per port |
| req_bar | input | NPORT x BID_W | Target barrier id per port |
| req_op | input | NPORT | 0 = sync (blocking), 1 = arrive (non-blocking) |
| req_count | input | NPORT x CNT_W | Expected participating thread count |
| warp_stall | output | NUM_WARPS | Warp held on a sync |
| warp_release | output | NUM_WARPS | One-cycle release pulse per warp |
| bar_done | output | NUM_BAR | One-cycle completion pulse per barrier |
| err_mismatch | output | NUM_BAR | Sticky target-disagreement flag |
| err_overflow | output | NUM_BAR | Sticky over-target flag |
| bar_gen | output | NUM_BAR x GEN_W | Generation counter per barrier |

## Verification
The in-RTL assertions check the following on every cycle. A partly filled barrier always stays below its target. A completion leaves the count at zero and moves the generation up by exactly one. Both error flags are sticky. A warp's stall bit only falls together with a release pulse, and a release never coincides with a stall. Only the bench scenarios can show which request completes a barrier, that a request from a held warp is ignored, that a mismatch or overflow is detected at all, the block-wide release of all 16 warps, and the wrap of a generation counter after sixteen reuses.

// File: rtl/nbar_pkg.sv
package nbar_pkg;
   typedef enum logic {
      OP_SYNC   = 1'b0,
      OP_ARRIVE = 1'b1
   } nbar_op_e;
endpackage

// File: rtl/nbar_slot.sv
module nbar_slot
   import nbar_pkg::*;
#(
   parameter int NPORT        = 2,
   parameter int CNT_W        = 10,
   parameter int GEN_W        = 4,
   parameter int WARP_THREADS = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NPORT-1:0]             hit,
   input  logic [NPORT-1:0][CNT_W-1:0]  cnt,
   output logic                         complete,
   output logic                         done_q,
   output logic [GEN_W-1:0]             gen_q,
   output logic                         mis_q,
   output logic                         ovf_q
);
   localparam int SUM_W = CNT_W + 1;

   logic [CNT_W-1:0] fill_q, tgt_q;
   logic [CNT_W-1:0] first_cnt, tgt_eff;
   logic [SUM_W-1:0] total;
   logic             found, any_mis;

   always_comb begin
      first_cnt = '0;
      found     = 1'b0;
      for (int p = 0; p < NPORT; p++) begin
         if (hit[p] && !found) begin
            first_cnt = cnt[p];
            found     = 1'b1;
         end
      end
      tgt_eff = (fill_q == '0) ? first_cnt : tgt_q;
      any_mis = 1'b0;
      total   = {1'b0, fill_q};
      for (int p = 0; p < NPORT; p++) begin
         if (hit[p]) begin
            total = total + SUM_W'(WARP_THREADS);
            if (cnt[p] != tgt_eff) any_mis = 1'b1;
         end
      end
      complete = found && (total >= {1'b0, tgt_eff});
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_q <= '0;
         tgt_q  <= '0;
         gen_q  <= '0;
         done_q <= 1'b0;
         mis_q  <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         done_q <= complete;
         if (any_mis) mis_q <= 1'b1;
         if (complete) begin
            fill_q <= '0;
            gen_q  <= gen_q + 1'b1;
            if (total > {1'b0, tgt_eff}) ovf_q <= 1'b1;
         end else if (found) begin
            fill_q <= total[CNT_W-1:0];
            tgt_q  <= tgt_eff;
         end
      end
   end

   assert_fill_below_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_q != '0) |-> (fill_q < tgt_q));
   assert_done_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (fill_q == '0));
   assert_gen_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (gen_q == $past(gen_q) + 1'b1));
   assert_mismatch_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mis_q |=> mis_q);
   assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q);
endmodule

// File: rtl/nbar_waiter.sv
module nbar_waiter
   import nbar_pkg::*;
#(
   parameter int NPORT   = 2,
   parameter int NUM_BAR = 16,
   parameter int WID_W   = 4,
   parameter int BID_W   = 4,
   parameter int MY_ID   = 0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NPORT-1:0]             acc,
   input  logic [NPORT-1:0][WID_W-1:0]  req_warp,
   input  logic [NPORT-1:0][BID_W-1:0]  req_bar,
   input  logic [NPORT-1:0]             req_op,
   input  logic [NUM_BAR-1:0]           done_now,
   output logic                         stall_q,
   output logic                         rel_q
);
   logic             iss;
   logic [BID_W-1:0] iss_bar, wait_bar_q;

   always_comb begin
      iss     = 1'b0;
      iss_bar = '0;
      for (int p = 0; p < NPORT; p++) begin
         if (acc[p] && (req_op[p] == OP_SYNC) && (req_warp[p] == WID_W'(MY_ID))) begin
            iss     = 1'b1;
            iss_bar = req_bar[p];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stall_q    <= 1'b0;
         rel_q      <= 1'b0;
         wait_bar_q <= '0;
      end else begin
         rel_q <= 1'b0;
         if (stall_q) begin
            if (done_now[wait_bar_q]) begin
               stall_q <= 1'b0;
               rel_q   <= 1'b1;
            end
         end else if (iss) begin
            if (done_now[iss_bar]) begin
               rel_q <= 1'b1;
            end else begin
               stall_q    <= 1'b1;
               wait_bar_q <= iss_bar;
            end
         end
      end
   end

   assert_release_not_stalled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rel_q |-> !stall_q);
   assert_unstall_with_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stall_q) |-> rel_q);
endmodule

// File: rtl/nbar_unit.sv
module nbar_unit
   import nbar_pkg::*;
#(
   parameter int NUM_BAR      = 16,
   parameter int NUM_WARPS    = 16,
   parameter int NPORT        = 2,
   parameter int WARP_THREADS = 32,
   parameter int CNT_W        = 10,
   parameter int GEN_W        = 4,
   localparam int BID_W       = $clog2(NUM_BAR),
   localparam int WID_W       = $clog2(NUM_WARPS)
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NPORT-1:0]                    req_valid,
   input  logic [NPORT-1:0][WID_W-1:0]         req_warp,
   input  logic [NPORT-1:0][BID_W-1:0]         req_bar,
   input  logic [NPORT-1:0]                    req_op,
   input  logic [NPORT-1:0][CNT_W-1:0]         req_count,
   output logic [NUM_WARPS-1:0]                warp_stall,
   output logic [NUM_WARPS-1:0]                warp_release,
   output logic [NUM_BAR-1:0]                  bar_done,
   output logic [NUM_BAR-1:0]                  err_mismatch,
   output logic [NUM_BAR-1:0]                  err_overflow,
   output logic [NUM_BAR-1:0][GEN_W-1:0]       bar_gen
);
   initial begin
      assert (NUM_BAR >= 2 && (1 << BID_W) == NUM_BAR)
         else $error("NUM_BAR must be a power of two");
      assert (NUM_WARPS >= 2 && (1 << WID_W) == NUM_WARPS)
         else $error("NUM_WARPS must be a power of two");
      assert (NPORT * WARP_THREADS < (1 << CNT_W))
         else $error("CNT_W too narrow for one cycle of arrivals");
      assert (NUM_WARPS * WARP_THREADS < (1 << CNT_W))
         else $error("CNT_W too narrow for a block-wide barrier");
   end

   logic [NPORT-1:0]   acc;
   logic [NUM_BAR-1:0] done_now;

   always_comb begin
      for (int p = 0; p < NPORT; p++)
         acc[p] = req_valid[p] && !warp_stall[req_warp[p]];
   end

   for (genvar b = 0; b < NUM_BAR; b++) begin : g_bar
      logic [NPORT-1:0] hit;
      always_comb begin
         for (int p = 0; p < NPORT; p++)
            hit[p] = acc[p] && (req_bar[p] == BID_W'(b));
      end
      nbar_slot #(
         .NPORT(NPORT), .CNT_W(CNT_W), .GEN_W(GEN_W), .WARP_THREADS(WARP_THREADS)
      ) u_slot (
         .clk(clk), .rst_n(rst_n), .hit(hit), .cnt(req_count),
         .complete(done_now[b]), .done_q(bar_done[b]), .gen_q(bar_gen[b]),
         .mis_q(err_mismatch[b]), .ovf_q(err_overflow[b])
      );
   end

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
      nbar_waiter #(
         .NPORT(NPORT), .NUM_BAR(NUM_BAR), .WID_W(WID_W), .BID_W(BID_W), .MY_ID(w)
      ) u_wait (
         .clk(clk), .rst_n(rst_n), .acc(acc), .req_warp(req_warp),
         .req_bar(req_bar), .req_op(req_op), .done_now(done_now),
         .stall_q(warp_stall[w]), .rel_q(warp_release[w])
      );
   end

   assert_release_needs_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (warp_release != '0) |-> (bar_done != '0));
endmodule

// File: tb/nbar_unit_tb.sv
`timescale 1ns/1ps
module nbar_unit_tb;
   localparam int NB = 16, NW = 16, NP = 2, CW = 10, GW = 4;
   localparam int BW = $clog2(NB), WW = $clog2(NW);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP-1:0]          req_valid;
   logic [NP-1:0][WW-1:0]  req_warp;
   logic [NP-1:0][BW-1:0]  req_bar;
   logic [NP-1:0]          req_op;
   logic [NP-1:0][CW-1:0]  req_count;
   logic [NW-1:0]          warp_stall, warp_release;
   logic [NB-1:0]          bar_done, err_mismatch, err_overflow;
   logic [NB-1:0][GW-1:0]  bar_gen;

   int checks = 0, errors = 0;

   typedef struct { int bar; int gen; } ev_t;
   ev_t sb_q[$];
   int  gen_model[NB];

   always #4 clk = ~clk;

   nbar_unit u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_warp(req_warp),
      .req_bar(req_bar), .req_op(req_op), .req_count(req_count),
      .warp_stall(warp_stall), .warp_release(warp_release), .bar_done(bar_done),
      .err_mismatch(err_mismatch), .err_overflow(err_overflow), .bar_gen(bar_gen)
   );

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic drive(int p, int w, int b, bit op, int c);
      req_valid[p] = 1'b1;
      req_warp[p]  = WW'(w);
      req_bar[p]   = BW'(b);
      req_op[p]    = op;
      req_count[p] = CW'(c);
   endtask

   task automatic expect_done(int b);
      ev_t e;
      gen_model[b] = (gen_model[b] + 1) % (1 << GW);
      e.bar = b;
      e.gen = gen_model[b];
      sb_q.push_back(e);
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      req_valid = '0;
   endtask

   // monitor: pops expected completions as the design reports them
   always @(negedge clk) begin
      if (rst_n) begin
         for (int b = 0; b < NB; b++) begin
            if (bar_done[b]) begin
               ev_t e;
               if (sb_q.size() == 0) begin
                  check("R4 unexpected completion", 64'(b), 64'hFFFF);
               end else begin
                  e = sb_q.pop_front();
                  check("R4 completion barrier", 64'(b), 64'(e.bar));
                  check("R6 completion generation", 64'(bar_gen[b]), 64'(e.gen));
               end
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      req_valid = '0; req_warp = '0; req_bar = '0; req_op = '0; req_count = '0;
      for (int b = 0; b < NB; b++) gen_model[b] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state
      check("R11 stall", 64'(warp_stall), 0);
      check("R11 release", 64'(warp_release), 0);
      check("R11 done", 64'(bar_done), 0);
      check("R11 errors", 64'({err_mismatch, err_overflow}), 0);
      check("R11 gen", 64'(bar_gen), 0);

      // R2 sync holds the warp
      drive(0, 2, 2, 1'b0, 64); step();
      check("R2 stall after sync", 64'(warp_stall), 64'h0004);
      check("R2 no completion", 64'(bar_done), 0);
      // R3 arrive completes, R5 release
      drive(0, 3, 2, 1'b1, 64); expect_done(2); step();
      check("R3/R5 stall cleared", 64'(warp_stall), 0);
      check("R5 release pulse", 64'(warp_release), 64'h0004);
      check("R6 gen after first use", 64'(bar_gen[2]), 1);
      step();
      check("R5 release one cycle", 64'(warp_release), 0);
      // R6 reuse, arrive first
      drive(0, 3, 2, 1'b1, 64); step();
      check("R3 arrive no stall", 64'(warp_stall), 0);
      check("R6 partial reuse", 64'(bar_done), 0);
      drive(0, 2, 2, 1'b0, 64); expect_done(2); step();
      check("R5 direct sync release", 64'(warp_release), 64'h0004);
      check("R6 gen after reuse", 64'(bar_gen[2]), 2);

      // R1 two barriers in one cycle
      drive(0, 4, 3, 1'b0, 32); drive(1, 5, 4, 1'b0, 32);
      expect_done(3); expect_done(4); step();
      check("R1 both done", 64'(bar_done), 64'h0018);
      check("R1 both released", 64'(warp_release), 64'h0030);

      // R4 two requests to one barrier in one cycle
      drive(0, 6, 5, 1'b0, 96); drive(1, 7, 5, 1'b0, 96); step();
      check("R4 partial", 64'(bar_done), 0);
      check("R4 two held", 64'(warp_stall), 64'h00C0);
      drive(0, 8, 5, 1'b1, 96); expect_done(5); step();
      check("R4/R5 group release", 64'(warp_release), 64'h00C0);
      check("R5 none held", 64'(warp_stall), 0);

      // R10 request from held warp ignored
      drive(0, 9, 6, 1'b0, 64); step();
      drive(0, 9, 6, 1'b1, 64); step();
      check("R10 no completion", 64'(bar_done), 0);
      check("R10 still held", 64'(warp_stall), 64'h0200);
      drive(0, 10, 6, 1'b1, 64); expect_done(6); step();
      check("R10 one arrival counted", 64'(warp_release), 64'h0200);

      // R7 block-wide barrier
      for (int i = 0; i < 8; i++) begin
         drive(0, 2*i, 0, 1'b0, 512); drive(1, 2*i+1, 0, 1'b0, 512);
         if (i == 7) expect_done(0);
         step();
         if (i == 6) check("R7 fourteen held", 64'(warp_stall), 64'h3FFF);
      end
      check("R7 all released", 64'(warp_release), 64'hFFFF);
      check("R7 none held", 64'(warp_stall), 0);

      // R8 count disagreement
      drive(0, 10, 7, 1'b1, 96); step();
      drive(0, 11, 7, 1'b1, 64); step();
      check("R8 mismatch flagged", 64'(err_mismatch), 64'h0080);
      check("R8 target kept", 64'(bar_done), 0);
      drive(0, 12, 7, 1'b1, 96); expect_done(7); step();
      check("R8 sticky", 64'(err_mismatch), 64'h0080);
      check("R9 no overflow at exact", 64'(err_overflow), 0);

      // R9 overflow
      drive(0, 13, 8, 1'b1, 16); expect_done(8); step();
      check("R9 overflow flagged", 64'(err_overflow), 64'h0100);
      step();
      check("R9 overflow sticky", 64'(err_overflow), 64'h0100);

      // R6 generation wrap
      for (int i = 0; i < 16; i++) begin
         drive(0, 14, 9, 1'b1, 32); expect_done(9); step();
      end
      check("R6 gen wraps", 64'(bar_gen[9]), 0);
      step();
      check("R4 scoreboard drained", 64'(sb_q.size()), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule